// File: doc/BRIEF.md
# Pluggable Module Slot Decoder with Local Bus Isolation

This block sits on a pluggable carrier module that holds several compute devices on one private 64-bit module bus. On every clock it samples the shared backplane access: a cycle strobe, a read/write flag, a board address and a device field. It compares the board address with the address strapped on the module's socket, so every module and every device image can stay identical. When the access is aimed at this module, the block raises the chip select of the addressed device and turns on the bidirectional transceiver between the backplane data bus and the module bus. It also sets the direction of that transceiver.

When the module is not addressed, the transceiver stays off. The devices may then use the module bus among themselves through a request/grant pair. The grant is withdrawn on the same clock edge on which the module becomes selected. Two forms of broadcast let one write reach all devices at once, for example during concurrent configuration. The first is a reserved all-ones board address. The second is an out-of-range device field when the mode input allows it. A broadcast read is refused, so the devices never drive the backplane together.

Top module: `mod_slot_iso`

## Requirements
- R1: While reset is held, all chip selects, the transceiver enable, both data output enables and the local grant are 0.
- R2: A cycle whose board address equals the slot strap and whose device field is below 6 sets only that device's chip select bit, which is bit index equal to the field, on the edge that samples it.
- R3: A cycle whose board address matches neither the slot strap nor the all-ones broadcast value leaves every chip select at 0 and the transceiver disabled.
- R4: A write to the all-ones board address sets all six chip selects, whatever the device field.
- R5: On a strap-matching cycle with device field 6 or 7, a write sets all six chip selects when all_mode is 1. When all_mode is 0, no chip select is set and the module stays unselected.
- R6: During a selected write, the transceiver is enabled with direction 0 (toward the local bus). loc_data_oe is 1, loc_data_o equals bp_data_i, and bp_data_oe is 0.
- R7: During a selected single-device read, the direction is 1 (toward the backplane). bp_data_oe is 1, bp_data_o equals loc_data_i, and loc_data_oe is 0.
- R8: A read that would select more than one device is ignored. This covers a read to the broadcast address and a read to field 6 or 7 with all_mode 1. No chip select is set, and bp_data_oe stays 0.
- R9: loc_gnt is 1 exactly when loc_req was 1 and the module was not selected, both sampled at the same edge. It therefore falls on the edge where selection rises.
- R10: When bus_cyc is 0, nothing is selected on the next edge, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 5 | Address strapped by the socket |
| all_mode | input | 1 | Device fields 6 and 7 select all devices (1) or none (0) |
| bus_cyc | input | 1 | Backplane access strobe |
| bus_wr | input | 1 | 1 = write toward devices, 0 = read |
| bd_addr | input | 5 | Board address of the access |
| dev_field | input | 3 | Device index of the access |
| bp_data_i | input | 64 | Backplane data seen at the transceiver |
| bp_data_o | output | 64 | Data driven onto the backplane |
| bp_data_oe | output | 1 | Backplane-side drive enable |
| loc_data_i | input | 64 | Module bus data seen at the transceiver |
| loc_data_o | output | 64 | Data driven onto the module bus |
| loc_data_oe | output | 1 | Module-side drive enable |
| loc_req | input | 1 | Devices request the isolated module bus |
| loc_gnt | output | 1 | Module bus granted to the devices |
| dev_cs | output | 6 | Per-device chip selects |
| xcvr_en | output | 1 | Transceiver enable |
| xcvr_dir_bp | output | 1 | Transceiver direction, 1 = toward backplane |

## Verification
The bench builds the block with its default parameters: six devices, a 5-bit board address, a 3-bit device field and 64-bit data. With the slot strap at 9, the two spare device codes 6 and 7 exist, so both settings of all_mode can be tested on them. Random accesses are weighted toward the strap and the all-ones address, so that single, broadcast, refused-read and foreign cycles all occur. Directed steps check that the grant falls on the same edge at which selection rises.

// File: rtl/mod_slot_iso_pkg.sv
package mod_slot_iso_pkg;
    typedef enum logic {
        DIR_TO_LOCAL = 1'b0,
        DIR_TO_BP    = 1'b1
    } xfer_dir_e;

    localparam int DEF_N_DEV  = 6;
    localparam int DEF_ADDR_W = 5;
    localparam int DEF_DATA_W = 64;
endpackage

// File: rtl/slot_addr_match.sv
module slot_addr_match #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] slot_id,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic              bus_cyc,
    output logic              hit_own,
    output logic              hit_bcast
);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    always_comb begin
        hit_bcast = bus_cyc && (bd_addr == BCAST_ADDR);
        hit_own   = bus_cyc && !hit_bcast && (bd_addr == slot_id);
    end
endmodule

// File: rtl/dev_cs_decode.sv
module dev_cs_decode #(
    parameter int N_DEV  = 6,
    parameter int DSEL_W = 3
) (
    input  logic              hit_own,
    input  logic              hit_bcast,
    input  logic              bus_wr,
    input  logic              all_mode,
    input  logic [DSEL_W-1:0] dev_field,
    output logic [N_DEV-1:0]  cs_next
);
    logic in_range;
    logic multi;
    logic single;

    always_comb begin
        in_range = int'(dev_field) < N_DEV;
        // a multi-device selection is only honoured on a write
        multi    = bus_wr && (hit_bcast || (hit_own && !in_range && all_mode));
        single   = hit_own && in_range;
    end

    for (genvar g = 0; g < N_DEV; g++) begin : g_cs
        assign cs_next[g] = multi || (single && (dev_field == DSEL_W'(g)));
    end
endmodule

// File: rtl/xcvr_ctl.sv
module xcvr_ctl
    import mod_slot_iso_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              sel,
    input  xfer_dir_e         dir,
    input  logic [DATA_W-1:0] bp_data_i,
    input  logic [DATA_W-1:0] loc_data_i,
    output logic [DATA_W-1:0] bp_data_o,
    output logic              bp_data_oe,
    output logic [DATA_W-1:0] loc_data_o,
    output logic              loc_data_oe
);
    always_comb begin
        bp_data_oe  = sel && (dir == DIR_TO_BP);
        loc_data_oe = sel && (dir == DIR_TO_LOCAL);
        bp_data_o   = bp_data_oe  ? loc_data_i : '0;
        loc_data_o  = loc_data_oe ? bp_data_i  : '0;
    end
endmodule

// File: rtl/mod_slot_iso.sv
module mod_slot_iso
    import mod_slot_iso_pkg::*;
#(
    parameter int N_DEV  = DEF_N_DEV,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] slot_id,
    input  logic              all_mode,
    input  logic              bus_cyc,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [$clog2(N_DEV)-1:0] dev_field,
    input  logic [DATA_W-1:0] bp_data_i,
    output logic [DATA_W-1:0] bp_data_o,
    output logic              bp_data_oe,
    input  logic [DATA_W-1:0] loc_data_i,
    output logic [DATA_W-1:0] loc_data_o,
    output logic              loc_data_oe,
    input  logic              loc_req,
    output logic              loc_gnt,
    output logic [N_DEV-1:0]  dev_cs,
    output logic              xcvr_en,
    output logic              xcvr_dir_bp
);
    localparam int DSEL_W = $clog2(N_DEV);

    typedef struct packed {
        logic [N_DEV-1:0] cs;
        xfer_dir_e        dir;
        logic             gnt;
    } iso_state_t;

    iso_state_t st_d, st_q;
    logic             hit_own, hit_bcast;
    logic [N_DEV-1:0] cs_next;
    logic             sel_q;

    slot_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .slot_id   (slot_id),
        .bd_addr   (bd_addr),
        .bus_cyc   (bus_cyc),
        .hit_own   (hit_own),
        .hit_bcast (hit_bcast)
    );

    dev_cs_decode #(.N_DEV(N_DEV), .DSEL_W(DSEL_W)) u_dec (
        .hit_own   (hit_own),
        .hit_bcast (hit_bcast),
        .bus_wr    (bus_wr),
        .all_mode  (all_mode),
        .dev_field (dev_field),
        .cs_next   (cs_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_next;
        st_d.dir = bus_wr ? DIR_TO_LOCAL : DIR_TO_BP;
        // grant is cleared on the very edge that selection appears
        st_d.gnt = loc_req && (cs_next == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cs: '0, dir: DIR_TO_LOCAL, gnt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q       = |st_q.cs;
    assign dev_cs      = st_q.cs;
    assign loc_gnt     = st_q.gnt;
    assign xcvr_en     = sel_q;
    assign xcvr_dir_bp = sel_q && (st_q.dir == DIR_TO_BP);

    xcvr_ctl #(.DATA_W(DATA_W)) u_xcvr (
        .sel         (sel_q),
        .dir         (st_q.dir),
        .bp_data_i   (bp_data_i),
        .loc_data_i  (loc_data_i),
        .bp_data_o   (bp_data_o),
        .bp_data_oe  (bp_data_oe),
        .loc_data_o  (loc_data_o),
        .loc_data_oe (loc_data_oe)
    );

    p_grant_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loc_gnt |-> !xcvr_en && !bp_data_oe && !loc_data_oe);

    p_read_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_data_oe |-> $countones(dev_cs) == 1);

    p_idle_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |=> dev_cs == '0);

    p_one_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_data_oe && loc_data_oe));

    p_foreign_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_addr != slot_id && bd_addr != '1) |=> !xcvr_en);

    p_write_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_wr) |=> !bp_data_oe);
endmodule

// File: tb/tb_mod_slot_iso.sv
module tb_mod_slot_iso;
    localparam int N = 6;
    localparam logic [4:0] SLOT = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  slot_id;
    logic        all_mode, bus_cyc, bus_wr, loc_req;
    logic [4:0]  bd_addr;
    logic [2:0]  dev_field;
    logic [63:0] bp_data_i, loc_data_i, bp_data_o, loc_data_o;
    logic        bp_data_oe, loc_data_oe, loc_gnt, xcvr_en, xcvr_dir_bp;
    logic [N-1:0] dev_cs;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mod_slot_iso dut (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .all_mode(all_mode),
        .bus_cyc(bus_cyc), .bus_wr(bus_wr), .bd_addr(bd_addr), .dev_field(dev_field),
        .bp_data_i(bp_data_i), .bp_data_o(bp_data_o), .bp_data_oe(bp_data_oe),
        .loc_data_i(loc_data_i), .loc_data_o(loc_data_o), .loc_data_oe(loc_data_oe),
        .loc_req(loc_req), .loc_gnt(loc_gnt), .dev_cs(dev_cs),
        .xcvr_en(xcvr_en), .xcvr_dir_bp(xcvr_dir_bp)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_cs(input logic cyc, input logic wr,
                                            input logic [4:0] a, input logic [2:0] d,
                                            input logic m);
        logic [N-1:0] r = '0;
        if (!cyc) return r;
        if (a == 5'h1F) return wr ? {N{1'b1}} : '0;
        if (a != SLOT) return r;
        if (int'(d) < N) r[d] = 1'b1;
        else if (m && wr) r = {N{1'b1}};
        return r;
    endfunction

    function automatic string tag_of(input logic cyc, input logic wr,
                                     input logic [4:0] a, input logic [2:0] d,
                                     input logic m);
        if (!cyc) return "R10";
        if (a == 5'h1F) return wr ? "R4" : "R8";
        if (a != SLOT) return "R3";
        if (int'(d) < N) return wr ? "R6" : "R7";
        if (m) return wr ? "R5" : "R8";
        return "R5";
    endfunction

    task automatic step(input logic cyc, input logic wr, input logic [4:0] a,
                        input logic [2:0] d, input logic m, input logic rq);
        logic [N-1:0] e;
        logic sel;
        string t;
        bus_cyc = cyc; bus_wr = wr; bd_addr = a; dev_field = d; all_mode = m; loc_req = rq;
        bp_data_i = {$urandom, $urandom}; loc_data_i = {$urandom, $urandom};
        @(posedge clk); #5;
        e   = exp_cs(cyc, wr, a, d, m);
        sel = |e;
        t   = tag_of(cyc, wr, a, d, m);
        chk({t, " cs"}, 64'(dev_cs), 64'(e));
        if (cyc && a == SLOT && int'(d) < N) chk("R2 cs", 64'(dev_cs), 64'(1) << d);
        chk({t, " en"}, 64'(xcvr_en), 64'(sel));
        chk({t, " dir"}, 64'(xcvr_dir_bp), 64'(sel && !wr));
        chk({t, " bp_oe"}, 64'(bp_data_oe), 64'(sel && !wr));
        chk({t, " loc_oe"}, 64'(loc_data_oe), 64'(sel && wr));
        if (sel && !wr) chk("R7 bp_data", bp_data_o, loc_data_i);
        if (sel && wr)  chk("R6 loc_data", loc_data_o, bp_data_i);
        chk("R9 gnt", 64'(loc_gnt), 64'(rq && !sel));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        slot_id = SLOT; rst_n = 1'b0; all_mode = 1'b1; bus_cyc = 1'b1; bus_wr = 1'b1;
        bd_addr = SLOT; dev_field = 3'd2; loc_req = 1'b1;
        bp_data_i = '1; loc_data_i = '1;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset holds everything inactive despite a matching access
        chk("R1 cs", 64'(dev_cs), 0);
        chk("R1 en", 64'(xcvr_en), 0);
        chk("R1 bp_oe", 64'(bp_data_oe), 0);
        chk("R1 loc_oe", 64'(loc_data_oe), 0);
        chk("R1 gnt", 64'(loc_gnt), 0);
        @(negedge clk); rst_n = 1'b1;

        // directed corners
        step(1, 0, SLOT, 3'd0, 0, 1);   // R2/R7 single read, grant drops R9
        step(0, 0, SLOT, 3'd0, 0, 1);   // R10 grant returns
        step(1, 1, SLOT, 3'd5, 0, 1);   // R2/R6 top device
        step(1, 1, 5'h1F, 3'd3, 0, 0);  // R4 broadcast address write
        step(1, 0, 5'h1F, 3'd3, 1, 1);  // R8 broadcast read refused
        step(1, 1, SLOT, 3'd6, 1, 0);   // R5 all
        step(1, 1, SLOT, 3'd7, 0, 1);   // R5 none, grant kept
        step(1, 0, SLOT, 3'd7, 1, 1);   // R8 multi read refused
        step(1, 1, 5'd3, 3'd1, 1, 1);   // R3 foreign
        step(0, 1, 5'h1F, 3'd1, 1, 0);  // R10 idle

        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            case ($urandom % 4)
                0, 1: a = SLOT;
                2:    a = 5'h1F;
                default: a = 5'($urandom);
            endcase
            step(($urandom % 8) != 0, 1'($urandom), a, 3'($urandom),
                 1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule